// File: doc/BRIEF.md
# Weighted Round-Robin Egress Arbiter

One instance sits in front of a single output port of a packet switch and decides which of its ingress lanes may send into that port. Every lane keeps a budget of packet starts. A lane whose budget is empty cannot win while another requesting lane still has budget left. When every requesting lane has an empty budget, all budgets refill from a shared default weight. The refill happens in the same cycle as the decision, so a lane that has just been refilled can win in that cycle.

Among lanes with budget left, selection rotates. The search starts at the lane after the one whose packet was last started, and it wraps around. Once a flit is accepted from the winner and that flit is not marked as a tail, the grant locks onto that lane. It stays there until the lane's tail flit is accepted, so packets are never interleaved on the port. The grant is combinational from the registered state and the present request, head, tail and default inputs. A transfer strobe from the downstream side tells the arbiter when a flit actually moved.

Top module: `wrr_egress_arb`

## Requirements
- R1: `gnt_o` has at most one bit set. When no lane requests and no packet is in flight, `gnt_o` is zero, and an idle cycle does not move the rotation.
- R2: While no packet is in flight, only a requesting lane is granted. A requesting lane with an empty budget loses to any requesting lane with budget left, even when the rotation would reach it first.
- R3: Each accepted flit from the granted lane with its `head_i` bit set (bit k belongs to lane k) uses up exactly one unit of that lane's budget.
- R4: In a cycle with no packet in flight, some lane requesting, and every requesting lane's budget empty, all budgets refill to `dflt_weight_i` and the grant in that same cycle is chosen from the refilled budgets.
- R5: After a head flit of lane i is accepted, the next search begins at lane i+1, and lane 0 follows lane N-1.
- R6: An accepted flit from the granted lane with its `tail_i` bit clear keeps `gnt_o` on that lane, whatever the requests, until a flit with its `tail_i` bit set is accepted. After that flit, the lane is released.
- R7: After reset, with the default weight held steady, `gnt_o` is zero for no requests, the search starts at lane 0, no packet is in flight, and every lane behaves as if its budget equals `dflt_weight_i`.
- R8: With `dflt_weight_i` equal to zero and no packet in flight, no lane is ever granted.
- R9: A cycle with `xfer_i` high and `gnt_o` zero changes no budget, no rotation and no lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N | Request, one bit per ingress lane |
| head_i | input | N | Head-flit marker per lane, sampled with `xfer_i` |
| tail_i | input | N | Tail-flit marker per lane, sampled with `xfer_i` |
| xfer_i | input | 1 | Downstream accepted one flit from the granted lane this cycle |
| dflt_weight_i | input | WW | Refill value for every lane's budget |
| gnt_o | output | N | One-hot grant, or all zero |

## Verification
A wrong budget shows up as a lane that wins too often, or one that is skipped. This becomes visible within a few head flits, at the latest on the next refill, when the grant order departs from the modelled sequence. A wrong rotation pointer changes the winner on the very next contended cycle. A lock that is stuck, or released too early, shows at once: the grant moves while a packet is open, or stays on a lane after its tail. The bench compares every cycle's grant against a reference model of budgets, pointer and lock, with fixed default weights and also across several of them.

// File: rtl/wrr_pkg.sv
package wrr_pkg;
  typedef enum logic {
    HOLD_OPEN = 1'b0,
    HOLD_BUSY = 1'b1
  } hold_state_e;
endpackage

// File: rtl/wrr_weight_bank.sv
module wrr_weight_bank #(
  parameter int N  = 4,
  parameter int WW = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic [WW-1:0] dflt_i,
  input  logic          held_i,
  input  logic          take_i,
  input  logic [PW-1:0] take_idx_i,
  output logic [N-1:0]  elig_o,
  output logic          reload_o
);
  logic [WW-1:0] w_q   [N];
  logic [WW-1:0] eff_w [N];
  logic [N-1:0]  nz_q;

  always_comb begin
    for (int i = 0; i < N; i++) nz_q[i] = |w_q[i];
  end

  // refill when every requester is out of budget
  assign reload_o = ~held_i & (|req_i) & ~(|(req_i & nz_q));

  always_comb begin
    for (int i = 0; i < N; i++) begin
      eff_w[i]  = reload_o ? dflt_i : w_q[i];
      elig_o[i] = req_i[i] & (|eff_w[i]);
    end
  end

  // empty after reset: the first request refills, same as starting full
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) w_q[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (take_i && (take_idx_i == PW'(i))) begin
          w_q[i] <= (|eff_w[i]) ? eff_w[i] - 1'b1 : '0;
        end else if (reload_o) begin
          w_q[i] <= dflt_i;
        end
      end
    end
  end
endmodule

// File: rtl/wrr_rr_pick.sv
module wrr_rr_pick #(
  parameter int N = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  elig_i,
  input  logic [PW-1:0] ptr_i,
  output logic [N-1:0]  gnt_o,
  output logic [PW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    int pos;
    any_o = 1'b0;
    idx_o = '0;
    gnt_o = '0;
    for (int off = 0; off < N; off++) begin
      pos = int'(ptr_i) + off;
      if (pos >= N) pos = pos - N;
      if (!any_o && elig_i[pos]) begin
        any_o = 1'b1;
        idx_o = PW'(pos);
      end
    end
    if (any_o) gnt_o[idx_o] = 1'b1;
  end
endmodule

// File: rtl/wrr_hold_ctrl.sv
module wrr_hold_ctrl
  import wrr_pkg::*;
#(
  parameter int N = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  pick_gnt_i,
  input  logic [PW-1:0] pick_idx_i,
  input  logic          pick_any_i,
  input  logic          xfer_i,
  input  logic [N-1:0]  head_i,
  input  logic [N-1:0]  tail_i,
  output logic [N-1:0]  gnt_o,
  output logic [PW-1:0] gnt_idx_o,
  output logic [PW-1:0] ptr_o,
  output logic          held_o,
  output logic          take_o
);
  hold_state_e   st_q;
  logic [PW-1:0] owner_q;
  logic [PW-1:0] ptr_q;
  logic          fire;

  assign held_o    = (st_q == HOLD_BUSY);
  assign gnt_o     = held_o ? (N'(1) << owner_q) : pick_gnt_i;
  assign gnt_idx_o = held_o ? owner_q : pick_idx_i;
  assign fire      = xfer_i & (held_o | pick_any_i);
  assign take_o    = fire & head_i[gnt_idx_o];
  assign ptr_o     = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= HOLD_OPEN;
      owner_q <= '0;
      ptr_q   <= '0;
    end else begin
      if (fire) begin
        st_q    <= tail_i[gnt_idx_o] ? HOLD_OPEN : HOLD_BUSY;
        owner_q <= gnt_idx_o;
      end
      if (take_o) begin
        ptr_q <= (gnt_idx_o == PW'(N - 1)) ? '0 : gnt_idx_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wrr_egress_arb.sv
module wrr_egress_arb #(
  parameter int N  = 4,
  parameter int WW = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic [N-1:0]  head_i,
  input  logic [N-1:0]  tail_i,
  input  logic          xfer_i,
  input  logic [WW-1:0] dflt_weight_i,
  output logic [N-1:0]  gnt_o
);
  logic [N-1:0]  elig;
  logic          reload;
  logic [N-1:0]  pick_gnt;
  logic [PW-1:0] pick_idx;
  logic          pick_any;
  logic [PW-1:0] gnt_idx;
  logic [PW-1:0] ptr;
  logic          held;
  logic          take;

  wrr_weight_bank #(.N(N), .WW(WW)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .dflt_i     (dflt_weight_i),
    .held_i     (held),
    .take_i     (take),
    .take_idx_i (gnt_idx),
    .elig_o     (elig),
    .reload_o   (reload)
  );

  wrr_rr_pick #(.N(N)) u_pick (
    .elig_i (elig),
    .ptr_i  (ptr),
    .gnt_o  (pick_gnt),
    .idx_o  (pick_idx),
    .any_o  (pick_any)
  );

  wrr_hold_ctrl #(.N(N)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pick_gnt_i (pick_gnt),
    .pick_idx_i (pick_idx),
    .pick_any_i (pick_any),
    .xfer_i     (xfer_i),
    .head_i     (head_i),
    .tail_i     (tail_i),
    .gnt_o      (gnt_o),
    .gnt_idx_o  (gnt_idx),
    .ptr_o      (ptr),
    .held_o     (held),
    .take_o     (take)
  );
endmodule

// File: rtl/wrr_egress_arb_chk.sv
module wrr_egress_arb_chk #(
  parameter int N  = 4,
  parameter int WW = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [N-1:0]  req_i,
  input logic [N-1:0]  head_i,
  input logic [N-1:0]  tail_i,
  input logic          xfer_i,
  input logic [WW-1:0] dflt_weight_i,
  input logic [N-1:0]  gnt_o,
  input logic          held_i,
  input logic [PW-1:0] ptr_i
);
  a_r1_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  a_r1_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!held_i && req_i == '0) |-> gnt_o == '0);

  a_r2_req_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !held_i |-> (gnt_o & ~req_i) == '0);

  a_r6_hold_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && gnt_o != '0 && (tail_i & gnt_o) == '0) |=> gnt_o == $past(gnt_o));

  a_r8_zero_dflt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!held_i && dflt_weight_i == '0) |-> gnt_o == '0);

  // R5 and R9: rotation moves only on an accepted head flit
  a_r9_ptr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(xfer_i && (gnt_o & head_i) != '0) |=> $stable(ptr_i));
endmodule

bind wrr_egress_arb wrr_egress_arb_chk #(.N(N), .WW(WW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_i         (req_i),
  .head_i        (head_i),
  .tail_i        (tail_i),
  .xfer_i        (xfer_i),
  .dflt_weight_i (dflt_weight_i),
  .gnt_o         (gnt_o),
  .held_i        (held),
  .ptr_i         (ptr)
);

// File: tb/wrr_egress_arb_tb.sv
`timescale 1ns/1ps
module wrr_egress_arb_tb_top;
  localparam int N  = 4;
  localparam int WW = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  req_i = '0;
  logic [N-1:0]  head_i = '0;
  logic [N-1:0]  tail_i = '0;
  logic          xfer_i = 1'b0;
  logic [WW-1:0] dflt_weight_i = '0;
  logic [N-1:0]  gnt_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  int m_w[N];
  int m_ptr;
  bit m_held;
  int m_own;

  always #2 clk_i = ~clk_i;

  wrr_egress_arb #(.N(N), .WW(WW)) dut_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_i         (req_i),
    .head_i        (head_i),
    .tail_i        (tail_i),
    .xfer_i        (xfer_i),
    .dflt_weight_i (dflt_weight_i),
    .gnt_o         (gnt_o)
  );

  function automatic bit m_reload(logic [N-1:0] rq);
    bit any_nz = 1'b0;
    for (int i = 0; i < N; i++) if (rq[i] && m_w[i] != 0) any_nz = 1'b1;
    return !m_held && rq != '0 && !any_nz;
  endfunction

  function automatic logic [N-1:0] m_grant(logic [N-1:0] rq, int dflt);
    bit rl;
    int p;
    if (m_held) return N'(1) << m_own;
    rl = m_reload(rq);
    for (int off = 0; off < N; off++) begin
      p = (m_ptr + off) % N;
      if (rq[p] && (rl ? dflt : m_w[p]) != 0) return N'(1) << p;
    end
    return '0;
  endfunction

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: gnt_o=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_reset(int dflt);
    @(negedge clk_i);
    rst_ni = 1'b0;
    req_i = '0; head_i = '0; tail_i = '0; xfer_i = 1'b0;
    dflt_weight_i = WW'(dflt);
    #1 check("R7 reset grant", gnt_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < N; i++) m_w[i] = dflt;
    m_ptr = 0; m_held = 1'b0; m_own = 0;
  endtask

  // drive one cycle, compare against model (and an optional literal), update model
  task automatic cyc(logic [N-1:0] rq, logic [N-1:0] hd, logic [N-1:0] tl, bit xf,
                     bit use_lit, logic [N-1:0] lit, string tag);
    logic [N-1:0] g;
    bit rl;
    int idx;
    int dflt;
    @(negedge clk_i);
    req_i = rq; head_i = hd; tail_i = tl; xfer_i = xf;
    dflt = int'(dflt_weight_i);
    #1;
    g = m_grant(rq, dflt);
    check(tag, gnt_o, g);
    if (use_lit) check({tag, " literal"}, gnt_o, lit);
    rl = m_reload(rq);
    idx = 0;
    for (int i = 0; i < N; i++) if (g[i]) idx = i;
    if (rl) for (int i = 0; i < N; i++) m_w[i] = dflt;
    if (xf && g != '0) begin
      if (hd[idx]) begin
        m_w[idx] = (m_w[idx] > 0) ? m_w[idx] - 1 : 0;
        m_ptr = (idx + 1) % N;
      end
      m_held = !tl[idx];
      m_own = idx;
    end
  endtask

  initial begin
    int unsigned seed;
    logic [N-1:0] all1;
    all1 = '1;
    seed = $urandom(32'd20250611);

    // R7 and R1: reset state and idle
    do_reset(1);
    cyc('0, '0, '0, 1'b0, 1'b1, 4'b0000, "R1 idle no grant");
    cyc(4'b1111, all1, all1, 1'b1, 1'b1, 4'b0001, "R7 search starts at lane 0");

    // R9: strobe without grant changes nothing, rotation stays at 0
    do_reset(1);
    cyc('0, all1, all1, 1'b1, 1'b1, 4'b0000, "R9 strobe without grant");
    cyc(4'b1111, all1, all1, 1'b1, 1'b1, 4'b0001, "R9 rotation unmoved");

    // R2 R3 R4: budgets of 2
    do_reset(2);
    cyc(4'b0001, all1, all1, 1'b1, 1'b1, 4'b0001, "R3 lane0 first start");
    cyc(4'b0001, all1, all1, 1'b1, 1'b1, 4'b0001, "R3 lane0 second start");
    cyc(4'b0011, all1, all1, 1'b1, 1'b1, 4'b0010, "R2 lane1 has budget");
    cyc(4'b0011, all1, all1, 1'b1, 1'b1, 4'b0010, "R2 empty lane0 skipped");
    cyc(4'b0011, all1, all1, 1'b1, 1'b1, 4'b0001, "R4 refill and grant same cycle");

    // R5: wrap from last lane to lane 0
    do_reset(3);
    cyc(4'b1000, all1, all1, 1'b1, 1'b1, 4'b1000, "R5 last lane");
    cyc(4'b1001, all1, all1, 1'b1, 1'b1, 4'b0001, "R5 wrap to lane 0");
    cyc(4'b1111, all1, all1, 1'b1, 1'b1, 4'b0010, "R5 next after lane 0");

    // R6: packet hold
    do_reset(3);
    cyc(4'b0011, 4'b0001, '0, 1'b1, 1'b1, 4'b0001, "R6 head accepted");
    cyc(4'b0010, '0, '0, 1'b0, 1'b1, 4'b0001, "R6 hold without request");
    cyc(4'b0011, '0, '0, 1'b1, 1'b1, 4'b0001, "R6 body flit");
    cyc(4'b0011, '0, 4'b0001, 1'b1, 1'b1, 4'b0001, "R6 tail flit");
    cyc(4'b0011, all1, all1, 1'b1, 1'b1, 4'b0010, "R6 released");

    // R8: zero default
    do_reset(0);
    cyc(4'b1111, all1, all1, 1'b1, 1'b1, 4'b0000, "R8 zero weight");
    cyc(4'b0100, all1, all1, 1'b1, 1'b1, 4'b0000, "R8 zero weight again");

    // random segments, one default weight each
    for (int s = 0; s < 5; s++) begin
      int dw;
      dw = (s == 4) ? 15 : s + 1;
      do_reset(dw);
      for (int c = 0; c < 1500; c++) begin
        logic [N-1:0] rq;
        logic [N-1:0] hd;
        logic [N-1:0] tl;
        bit xf;
        rq = N'($urandom);
        if ($urandom % 8 == 0) rq = '0;
        hd = N'($urandom);
        tl = ($urandom % 2 == 0) ? all1 : N'($urandom);
        xf = ($urandom % 10) < 7;
        cyc(rq, hd, tl, xf, 1'b0, '0, "R1 R2 R3 R4 R5 R6 random");
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule